// File: doc/BRIEF.md
# Byte-accessed 32-bit event counter

This block keeps a free-running 32-bit tick count and compares it against three 32-bit compare values. It sits behind a narrow register bus that moves 8 bits per access. Every 32-bit register is reached one byte at a time through a single holding register that all of them share, so that software always sees, and always writes, a coherent 32-bit value.

To read a 32-bit register, software reads byte 0 first. That read copies the whole live value into the holding register, and bytes 1 to 3 are then returned from that copy. To write a 32-bit register, software writes bytes 3, 2 and 1, which only fill the holding register, and finishes with byte 0, which moves all 32 bits to the target in one step. The holding register is not protected: if software touches another 32-bit register partway through a sequence, that sequence is corrupted.

Ticks arrive as single-cycle enables on one of two inputs, a fast one and a slow one, and a control bit selects between them. A written counter value is held pending until the next accepted tick, and the busy bit stays at one for that whole time. Status flags are set by counter wrap, by a compare match or by an external backoff event, and software clears them by writing ones. A mask register chooses which flags drive the single registered interrupt output. The bus is a plain register port with no back-pressure: a write takes effect at the clock edge where it is presented, and read data is valid one cycle after the read strobe.

Top module: `byte_event_counter`

## Requirements
- R1: After reset the control, status, mask and busy registers read 0x00, the counter reads 0 and irq is low.
- R2: Writing counter bytes 3, 2, 1 and then byte 0 (byte offsets 0x04 to 0x07) sets busy (address 0x03, bit 0) to one. The next accepted tick loads the written value in place of an increment and clears busy, and each later accepted tick adds one.
- R3: When the enable bit (control address 0x00, bit 0) is zero, ticks on either input leave the counter unchanged.
- R4: Source select (control bit 1) chooses the tick input: 0 selects tick_fast, 1 selects tick_slow. Pulses on the input that is not selected are ignored.
- R5: A tick at 0xFFFFFFFF wraps the counter to 0 and sets the overflow flag (status bit 3).
- R6: A read of byte 0 of a 32-bit register snapshots the live value. Later reads of bytes 1 to 3 return that snapshot even if the counter has moved since.
- R7: When an accepted tick brings the counter equal to compare register k (k = 1, 2, 3, at bases 0x08, 0x0C and 0x10), status bit k-1 is set.
- R8: Writing a one to a status bit (address 0x01) clears that flag. Zero bits leave their flags unchanged.
- R9: irq, one cycle after the state it reflects, is the OR of the status bits ANDed with the mask bits (address 0x02, same bit layout). Masked flags still set.
- R10: Only one holding register exists. A byte 1 to 3 write to another 32-bit register in the middle of a write sequence replaces that byte in the value that byte 0 later commits.
- R11: Control bits 0, 1 and 3 (bit 3 is timestamp enable) read back as written. Bit 2, the prescaler reset, always reads 0 and discards any tick in the cycle after it is written.
- R12: A pulse on backoff_evt sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_rd | input | 1 | Read strobe, data valid one cycle later |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| backoff_evt | input | 1 | Backoff event pulse |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench loads the counter and reads bytes 1 to 3 after further ticks. A design that reads the live value instead of the snapshot returns the new upper byte. It interleaves a write to a second 32-bit register inside a compare write sequence, where a design that keeps private holding registers commits the clean value and fails the check. It also drives ticks while the counter is disabled and on the source that is not selected, where a design that leaks ticks shows a changed count. Finally it takes the counter through the wrap at 0xFFFFFFFF. In that test a design that flags overflow on a load, or misses it on the increment, shows the wrong status. It also probes write-one-clear with zero bits and unset bits, and checks that a masked flag holds irq low.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 32;
  localparam int N_CMP  = 3;
  localparam int N_FLAG = N_CMP + 2;
  localparam int CTRL_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h01;
  localparam logic [ADDR_W-1:0] A_MASK = 5'h02;
  localparam logic [ADDR_W-1:0] A_BUSY = 5'h03;

  localparam int C_EN   = 0;
  localparam int C_SRC  = 1;
  localparam int C_PRST = 2;
  localparam int C_TSE  = 3;

  localparam int F_OVF = N_CMP;
  localparam int F_BKO = N_CMP + 1;
endpackage

// File: rtl/evc_core.sv
module evc_core import evc_pkg::*; #(
  parameter int W  = CNT_W,
  parameter int NC = N_CMP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 src_slow,
  input  logic                 prst,
  input  logic                 tick_fast,
  input  logic                 tick_slow,
  input  logic                 ld_req,
  input  logic [W-1:0]         ld_val,
  input  logic [NC-1:0][W-1:0] cmp_vals,
  output logic [W-1:0]         cnt,
  output logic                 busy,
  output logic [NC:0]          evt
);
  logic [W-1:0] ldv;
  logic         pend;
  logic         tick;
  logic [W-1:0] nxt;

  assign tick = en & (src_slow ? tick_slow : tick_fast) & ~prst;
  assign nxt  = pend ? ldv : cnt + 1'b1;
  assign busy = pend;

  generate
    for (genvar k = 0; k < NC; k++) begin : g_match
      assign evt[k] = tick & (nxt == cmp_vals[k]);
    end
  endgenerate
  assign evt[NC] = tick & ~pend & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ldv  <= '0;
      pend <= 1'b0;
    end else begin
      if (tick) cnt <= nxt;
      if (ld_req) begin
        ldv  <= ld_val;
        pend <= 1'b1;
      end else if (tick) begin
        pend <= 1'b0;
      end
    end
  end

  AST_LOAD_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tick && !ld_req) |=> (!busy && cnt == $past(ldv))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(cnt)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend && (&cnt)) |=> (cnt == '0)); // R5
endmodule

// File: rtl/evc_regif.sv
module evc_regif import evc_pkg::*; #(
  parameter int AW = ADDR_W,
  parameter int W  = CNT_W,
  parameter int NC = N_CMP,
  parameter int NF = N_FLAG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [W-1:0]         cnt,
  input  logic                 busy,
  input  logic [NF-1:0]        set_flags,
  output logic [CTRL_W-1:0]    ctrl_q,
  output logic [NF-1:0]        mask_q,
  output logic [NF-1:0]        stat_q,
  output logic                 cnt_wr,
  output logic [W-1:0]         cnt_wval,
  output logic [NC-1:0][W-1:0] cmp_q
);
  localparam int NB = W / 8;
  localparam int BW = $clog2(NB);
  localparam int WI = AW - BW;

  logic [W-1:0]    hold;
  logic [W-1:0]    live;
  logic [WI-1:0]   widx;
  logic [BW-1:0]   bsel;
  logic            is_word;
  logic            commit;
  logic [W-1:0]    wfull;

  assign widx    = addr[AW-1:BW];
  assign bsel    = addr[BW-1:0];
  assign is_word = (widx >= WI'(1)) && (widx <= WI'(NC + 1));
  assign commit  = wr_en && is_word && (bsel == '0);
  assign wfull   = {hold[W-1:8], wdata};
  assign cnt_wr  = commit && (widx == WI'(1));
  assign cnt_wval = wfull;

  always_comb begin
    live = cnt;
    for (int k = 0; k < NC; k++) begin
      if (widx == WI'(k + 2)) live = cmp_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      rdata <= '0;
    end else begin
      if (rd_en) begin
        if (is_word) begin
          if (bsel == '0) begin
            rdata <= live[7:0];
            hold  <= live;
          end else begin
            rdata <= hold[bsel*8 +: 8];
          end
        end else begin
          case (addr)
            A_CTRL:  rdata <= {4'b0, ctrl_q[C_TSE], 1'b0, ctrl_q[C_SRC], ctrl_q[C_EN]};
            A_STAT:  rdata <= {{(8-NF){1'b0}}, stat_q};
            A_MASK:  rdata <= {{(8-NF){1'b0}}, mask_q};
            A_BUSY:  rdata <= {7'b0, busy};
            default: rdata <= '0;
          endcase
        end
      end
      if (wr_en && is_word && (bsel != '0)) hold[bsel*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q[C_PRST] <= wr_en && (addr == A_CTRL) && wdata[C_PRST];
      if (wr_en && addr == A_CTRL) begin
        ctrl_q[C_EN]  <= wdata[C_EN];
        ctrl_q[C_SRC] <= wdata[C_SRC];
        ctrl_q[C_TSE] <= wdata[C_TSE];
      end
      if (wr_en && addr == A_MASK) mask_q <= wdata[NF-1:0];
      if (wr_en && addr == A_STAT) stat_q <= (stat_q & ~wdata[NF-1:0]) | set_flags;
      else                         stat_q <= stat_q | set_flags;
    end
  end

  generate
    for (genvar k = 0; k < NC; k++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rst_n)                             cmp_q[k] <= '0;
        else if (commit && widx == WI'(k + 2))  cmp_q[k] <= wfull;
      end
    end
  endgenerate

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && set_flags == '0) |=> ((stat_q & $past(wdata[NF-1:0])) == '0)); // R8
  AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata == 8'h00) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
  AST_PRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |=> (rdata[C_PRST] == 1'b0)); // R11
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] stat,
  input  logic [NF-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat & mask);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & mask) == '0) |=> !irq); // R9
  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & mask) != '0) |=> irq); // R9
endmodule

// File: rtl/byte_event_counter.sv
module byte_event_counter import evc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              backoff_evt,
  output logic              irq
);
  logic [CTRL_W-1:0]           ctrl_q;
  logic [N_FLAG-1:0]           mask_q;
  logic [N_FLAG-1:0]           stat_q;
  logic [N_FLAG-1:0]           set_flags;
  logic                        cnt_wr;
  logic [CNT_W-1:0]            cnt_wval;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]            cnt;
  logic                        busy;
  logic [N_CMP:0]              evt;

  assign set_flags = {backoff_evt, evt};

  evc_regif #(.AW(ADDR_W), .W(CNT_W), .NC(N_CMP), .NF(N_FLAG)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .busy(busy),
    .set_flags(set_flags), .ctrl_q(ctrl_q), .mask_q(mask_q), .stat_q(stat_q),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .cmp_q(cmp_q)
  );

  evc_core #(.W(CNT_W), .NC(N_CMP)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[C_EN]), .src_slow(ctrl_q[C_SRC]),
    .prst(ctrl_q[C_PRST]), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .ld_req(cnt_wr), .ld_val(cnt_wval), .cmp_vals(cmp_q),
    .cnt(cnt), .busy(busy), .evt(evt)
  );

  evc_irq #(.NF(N_FLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .mask(mask_q), .irq(irq)
  );
endmodule

// File: tb/byte_event_counter_tb.sv
module byte_event_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_fast = 1'b0;
  logic       tick_slow = 1'b0;
  logic       backoff_evt = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  localparam logic [4:0] CTRL = 5'h00, STAT = 5'h01, MASK = 5'h02, BUSY = 5'h03;
  localparam logic [4:0] CNT = 5'h04, CMP1 = 5'h08, CMP2 = 5'h0C, CMP3 = 5'h10;

  byte_event_counter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .backoff_evt(backoff_evt), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(string t, logic act, logic e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [4:0] a, logic [7:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr32(logic [4:0] b, logic [31:0] v);
    wr(b + 5'd3, v[31:24]); wr(b + 5'd2, v[23:16]);
    wr(b + 5'd1, v[15:8]);  wr(b, v[7:0]);
  endtask

  task automatic rd32(logic [4:0] b, logic [31:0] v, string t);
    for (int i = 0; i < 4; i++) rd_exp(b + 5'(i), v[i*8 +: 8], t);
  endtask

  task automatic pulse_fast();
    @(negedge clk); tick_fast = 1'b1; @(negedge clk); tick_fast = 1'b0;
  endtask

  task automatic pulse_slow();
    @(negedge clk); tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    rd_exp(CTRL, 8'h00, "R1 ctrl");
    rd_exp(STAT, 8'h00, "R1 stat");
    rd_exp(MASK, 8'h00, "R1 mask");
    rd_exp(BUSY, 8'h00, "R1 busy");
    rd32(CNT, 32'h0, "R1 cnt");
    // R11 control readback, prescaler reset self-clears
    wr(CTRL, 8'h0D);
    rd_exp(CTRL, 8'h09, "R11 ctrl");
    wr(CTRL, 8'h01);
    // R2 pending load and busy
    wr32(CNT, 32'h12345678);
    rd_exp(BUSY, 8'h01, "R2 busy set");
    pulse_fast();
    rd_exp(BUSY, 8'h00, "R2 busy clear");
    rd32(CNT, 32'h12345678, "R2 loaded");
    pulse_fast();
    rd32(CNT, 32'h12345679, "R2 increment");
    // R3 disabled
    wr(CTRL, 8'h00);
    pulse_fast(); pulse_slow(); pulse_fast();
    rd32(CNT, 32'h12345679, "R3 disabled");
    // R4 source select
    wr(CTRL, 8'h01);
    pulse_slow();
    rd32(CNT, 32'h12345679, "R4 slow ignored");
    wr(CTRL, 8'h03);
    pulse_fast();
    rd32(CNT, 32'h12345679, "R4 fast ignored");
    pulse_slow();
    rd32(CNT, 32'h1234567A, "R4 slow counts");
    // R6 snapshot
    wr(CTRL, 8'h01);
    wr32(CNT, 32'h000000FF);
    pulse_fast();
    rd_exp(CNT, 8'hFF, "R6 byte0");
    pulse_fast();
    rd_exp(CNT + 5'd1, 8'h00, "R6 byte1 snapshot");
    rd32(CNT, 32'h00000100, "R6 fresh");
    // R10 shared holding register
    wr(CMP1 + 5'd3, 8'hAA); wr(CMP1 + 5'd2, 8'hAA); wr(CMP1 + 5'd1, 8'hAA);
    wr(CNT + 5'd1, 8'h55);
    wr(CMP1, 8'h01);
    rd32(CMP1, 32'hAAAA5501, "R10 corrupted");
    // R7 compare match
    wr32(CMP2, 32'h10);
    wr32(CMP3, 32'h20);
    rd_exp(STAT, 8'h00, "R7 none yet");
    wr32(CNT, 32'h0E);
    pulse_fast(); pulse_fast();
    rd_exp(STAT, 8'h00, "R7 before match");
    pulse_fast();
    rd_exp(STAT, 8'h02, "R7 cmp2 match");
    // R8 write one to clear
    wr(STAT, 8'h00);
    rd_exp(STAT, 8'h02, "R8 zero write");
    wr(STAT, 8'h01);
    rd_exp(STAT, 8'h02, "R8 other bit");
    wr(STAT, 8'h02);
    rd_exp(STAT, 8'h00, "R8 cleared");
    // R12 backoff
    @(negedge clk); backoff_evt = 1'b1; @(negedge clk); backoff_evt = 1'b0;
    rd_exp(STAT, 8'h10, "R12 backoff");
    // R9 mask and irq
    chk("R9 masked", irq, 1'b0);
    wr(MASK, 8'h10);
    @(negedge clk);
    chk("R9 unmasked", irq, 1'b1);
    wr(STAT, 8'h10);
    @(negedge clk);
    chk("R9 cleared", irq, 1'b0);
    // R5 wrap
    wr(STAT, 8'h1F);
    wr32(CNT, 32'hFFFFFFFF);
    pulse_fast();
    rd_exp(STAT, 8'h00, "R5 load no ovf");
    pulse_fast();
    rd32(CNT, 32'h0, "R5 wrapped");
    rd_exp(STAT, 8'h08, "R5 ovf flag");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule